// File: doc/BRIEF.md
# SD host interrupt status registers

This block gathers the event and error indications of an SD/MMC host controller into two 32-bit status words and pairs each word with a 32-bit mask register. The command and data engines of the host drive one event input per condition. The block sets the matching flag on the rising edge of that input, and the flag holds until software writes a zero to it. A single interrupt line rises whenever a set flag has its mask bit cleared.

Next to the sticky flags, the status words carry three live levels: the card-detect pin, the DAT0 pin and a command-busy indication. Software reads command busy before it issues a new command. The two pin levels pass through a two-stage synchronizer. Card insertion and removal flags come from the rising and falling edges of the synchronized card-detect level, so no separate event inputs exist for them.

Software reaches the block through a plain register port. A write takes effect at the clock edge where `reg_wr_i` is high. Read data is combinational from the address and appears in the same cycle. The port has no data stream and therefore no valid/ready handshake: every register access completes in one cycle and cannot be held off.

Top module: `sdirq_status_regs`

## Requirements
- R1: The first status word reads at byte address 0x038 and the second at 0x03C. Their masks read at 0x040 and 0x044. Any other address reads 0. Read data follows `reg_addr_i` in the same cycle.
- R2: After reset, every sticky flag is 0, both mask registers read 0xFFFFFFFF and `irq_o` is low.
- R3: A rising edge on an event input sets its flag at the next clock edge. In the first word, response done sets bit 0 and data done sets bit 2. In the second word the bits are: command index error 0, CRC error 1, end-bit error 2, timeout 3, illegal write 4, illegal read 5, response timeout 6, read buffer filled 8, write buffer emptied 9, illegal access 15.
- R4: An event input held high sets its flag only once. After software clears the flag, it stays 0 until the input falls and rises again. This covers read buffer ready while data is still pending.
- R5: A write to a status word clears each sticky bit written as 0 and leaves each sticky bit written as 1 unchanged.
- R6: When an event edge and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: The live levels are word 1 bit 5 (card detect, synchronized over two cycles), word 2 bit 7 (DAT0, synchronized) and word 2 bit 14 (command busy, direct). Writes to these bits have no effect.
- R8: A rising edge of the synchronized card-detect level sets word 1 bit 4 (inserted). A falling edge sets word 1 bit 3 (removed).
- R9: `irq_o` is high exactly when some sticky flag is 1 and its mask bit is 0. Mask bit 1 blocks the flag. Live levels never raise `irq_o`.
- R10: Each mask register stores all 32 written bits and reads them back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| resp_done_i | input | 1 | Response received event |
| data_done_i | input | 1 | Data transfer finished event |
| err_cmd_idx_i | input | 1 | Command index error event |
| err_crc_i | input | 1 | CRC error event |
| err_end_bit_i | input | 1 | End-bit error event |
| err_timeout_i | input | 1 | Data timeout event |
| err_ill_wr_i | input | 1 | Illegal write event |
| err_ill_rd_i | input | 1 | Illegal read event |
| err_resp_to_i | input | 1 | Response timeout event |
| rd_buf_fill_i | input | 1 | Read buffer filled event |
| wr_buf_empty_i | input | 1 | Write buffer emptied event |
| err_ill_acc_i | input | 1 | Illegal access event |
| card_det_i | input | 1 | Card-detect pin level (asynchronous) |
| dat0_i | input | 1 | DAT0 pin level (asynchronous) |
| cmd_busy_i | input | 1 | Command in progress level |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two situations are hard to reach from the ports. The first is a clearing write and an event edge landing on the same clock edge. The bench reaches it by driving the zero write and the event pulse on the same falling edge, so both are sampled together. The second is the edge-only setting of the buffer-ready flag. The bench holds the fill input high, clears the flag, and shows that the flag stays clear over several cycles until the input drops and rises again. Card insertion and removal are produced only through the card-detect pin, which makes the synchronizer latency part of every card check.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;

  localparam int REG_W  = 32;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_STAT1 = 12'h038;
  localparam logic [ADDR_W-1:0] OFS_STAT2 = 12'h03C;
  localparam logic [ADDR_W-1:0] OFS_MASK1 = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_MASK2 = 12'h044;

  // status word 1 bit positions
  localparam int B1_RESP   = 0;
  localparam int B1_DATA   = 2;
  localparam int B1_REMOVE = 3;
  localparam int B1_INSERT = 4;
  localparam int B1_CD     = 5;

  // status word 2 bit positions
  localparam int B2_IDX    = 0;
  localparam int B2_CRC    = 1;
  localparam int B2_ENDB   = 2;
  localparam int B2_TO     = 3;
  localparam int B2_ILW    = 4;
  localparam int B2_ILR    = 5;
  localparam int B2_RTO    = 6;
  localparam int B2_DAT0   = 7;
  localparam int B2_RDBUF  = 8;
  localparam int B2_WRBUF  = 9;
  localparam int B2_BUSY   = 14;
  localparam int B2_ILA    = 15;

  localparam logic [REG_W-1:0] STICKY1 =
      (REG_W'(1) << B1_RESP) | (REG_W'(1) << B1_DATA) |
      (REG_W'(1) << B1_REMOVE) | (REG_W'(1) << B1_INSERT);
  localparam logic [REG_W-1:0] LIVE1 = REG_W'(1) << B1_CD;

  localparam logic [REG_W-1:0] STICKY2 =
      (REG_W'(1) << B2_IDX) | (REG_W'(1) << B2_CRC) | (REG_W'(1) << B2_ENDB) |
      (REG_W'(1) << B2_TO) | (REG_W'(1) << B2_ILW) | (REG_W'(1) << B2_ILR) |
      (REG_W'(1) << B2_RTO) | (REG_W'(1) << B2_RDBUF) |
      (REG_W'(1) << B2_WRBUF) | (REG_W'(1) << B2_ILA);
  localparam logic [REG_W-1:0] LIVE2 =
      (REG_W'(1) << B2_DAT0) | (REG_W'(1) << B2_BUSY);

  // number of edge-detected event inputs
  localparam int N_EVT = 12;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ST1,
    SEL_ST2,
    SEL_MK1,
    SEL_MK2
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_STAT1: decode_addr = SEL_ST1;
      OFS_STAT2: decode_addr = SEL_ST2;
      OFS_MASK1: decode_addr = SEL_MK1;
      OFS_MASK2: decode_addr = SEL_MK2;
      default:   decode_addr = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/sdirq_level_sync.sv
module sdirq_level_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign sync_o = async_i;
    end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
          stage_q[0] <= async_i;
          for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
      end

      assign sync_o = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/sdirq_edge_det.sv
module sdirq_edge_det #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;

  // a held level must not produce a second set pulse
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((rise_o & $past(rise_o)) == '0)); // R4

endmodule

// File: rtl/sdirq_flag_bank.sv
module sdirq_flag_bank #(
  parameter int               WIDTH    = 32,
  parameter logic [WIDTH-1:0] STICKY   = '0,
  parameter logic [WIDTH-1:0] LIVE     = '0,
  parameter logic [WIDTH-1:0] MASK_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic             stat_wr_i,
  input  logic             mask_wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] live_i,
  output logic [WIDTH-1:0] stat_o,
  output logic [WIDTH-1:0] mask_o,
  output logic             irq_o
);

  localparam logic [WIDTH-1:0] KEEP_ALL = '1;

  logic [WIDTH-1:0] flags_q, flags_d;
  logic [WIDTH-1:0] mask_q;
  logic [WIDTH-1:0] keep_vec;

  always_comb begin
    keep_vec = stat_wr_i ? wdata_i : KEEP_ALL;
    flags_d  = ((flags_q & keep_vec) | set_i) & STICKY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= MASK_RST;
    else if (mask_wr_i) mask_q <= wdata_i;
  end

  assign stat_o = flags_q | (live_i & LIVE);
  assign mask_o = mask_q;
  assign irq_o  = |(flags_q & ~mask_q);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i & STICKY) != '0) |=> ((flags_q & $past(set_i & STICKY)) == $past(set_i & STICKY))); // R6

  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr_i && wdata_i == '0 && set_i == '0) |=> (flags_q == '0)); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr_i && set_i == '0) |=> $stable(flags_q)); // R5

endmodule

// File: rtl/sdirq_status_regs.sv
module sdirq_status_regs
  import sdirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              resp_done_i,
  input  logic              data_done_i,
  input  logic              err_cmd_idx_i,
  input  logic              err_crc_i,
  input  logic              err_end_bit_i,
  input  logic              err_timeout_i,
  input  logic              err_ill_wr_i,
  input  logic              err_ill_rd_i,
  input  logic              err_resp_to_i,
  input  logic              rd_buf_fill_i,
  input  logic              wr_buf_empty_i,
  input  logic              err_ill_acc_i,
  input  logic              card_det_i,
  input  logic              dat0_i,
  input  logic              cmd_busy_i,
  output logic              irq_o
);

  reg_sel_e sel;
  assign sel = decode_addr(reg_addr_i);

  // event edge detection
  logic [N_EVT-1:0] ev_raw, ev_rise, ev_fall_unused;
  assign ev_raw = {err_ill_acc_i, wr_buf_empty_i, rd_buf_fill_i, err_resp_to_i,
                   err_ill_rd_i, err_ill_wr_i, err_timeout_i, err_end_bit_i,
                   err_crc_i, err_cmd_idx_i, data_done_i, resp_done_i};

  sdirq_edge_det #(.WIDTH(N_EVT)) u_evt_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (ev_raw),
    .rise_o  (ev_rise),
    .fall_o  (ev_fall_unused)
  );

  // pin synchronizer: bit 0 card detect, bit 1 DAT0
  logic [1:0] pin_s;
  sdirq_level_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({dat0_i, card_det_i}),
    .sync_o  (pin_s)
  );

  logic cd_rise, cd_fall;
  sdirq_edge_det #(.WIDTH(1)) u_cd_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (pin_s[0]),
    .rise_o  (cd_rise),
    .fall_o  (cd_fall)
  );

  // set and live vectors per word
  logic [REG_W-1:0] set1, set2, live1, live2;
  always_comb begin
    set1 = '0;
    set1[B1_RESP]   = ev_rise[0];
    set1[B1_DATA]   = ev_rise[1];
    set1[B1_REMOVE] = cd_fall;
    set1[B1_INSERT] = cd_rise;

    set2 = '0;
    set2[B2_IDX]   = ev_rise[2];
    set2[B2_CRC]   = ev_rise[3];
    set2[B2_ENDB]  = ev_rise[4];
    set2[B2_TO]    = ev_rise[5];
    set2[B2_ILW]   = ev_rise[6];
    set2[B2_ILR]   = ev_rise[7];
    set2[B2_RTO]   = ev_rise[8];
    set2[B2_RDBUF] = ev_rise[9];
    set2[B2_WRBUF] = ev_rise[10];
    set2[B2_ILA]   = ev_rise[11];

    live1 = '0;
    live1[B1_CD] = pin_s[0];
    live2 = '0;
    live2[B2_DAT0] = pin_s[1];
    live2[B2_BUSY] = cmd_busy_i;
  end

  logic [REG_W-1:0] stat1, stat2, mask1, mask2;
  logic             irq1, irq2;

  sdirq_flag_bank #(
    .WIDTH(REG_W), .STICKY(STICKY1), .LIVE(LIVE1), .MASK_RST('1)
  ) u_bank1 (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (set1),
    .stat_wr_i (reg_wr_i && sel == SEL_ST1),
    .mask_wr_i (reg_wr_i && sel == SEL_MK1),
    .wdata_i   (reg_wdata_i),
    .live_i    (live1),
    .stat_o    (stat1),
    .mask_o    (mask1),
    .irq_o     (irq1)
  );

  sdirq_flag_bank #(
    .WIDTH(REG_W), .STICKY(STICKY2), .LIVE(LIVE2), .MASK_RST('1)
  ) u_bank2 (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (set2),
    .stat_wr_i (reg_wr_i && sel == SEL_ST2),
    .mask_wr_i (reg_wr_i && sel == SEL_MK2),
    .wdata_i   (reg_wdata_i),
    .live_i    (live2),
    .stat_o    (stat2),
    .mask_o    (mask2),
    .irq_o     (irq2)
  );

  always_comb begin
    case (sel)
      SEL_ST1: reg_rdata_o = stat1;
      SEL_ST2: reg_rdata_o = stat2;
      SEL_MK1: reg_rdata_o = mask1;
      SEL_MK2: reg_rdata_o = mask2;
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = irq1 | irq2;

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask1 == '1 && mask2 == '1) |-> !irq_o); // R9

  AST_LIVE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (((stat1 & STICKY1) == '0) && ((stat2 & STICKY2) == '0)) |-> !irq_o); // R9

  AST_BUSY_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_ST2) |-> (reg_rdata_o[B2_BUSY] == cmd_busy_i)); // R7

endmodule

// File: tb/tb_sdirq_status_regs.sv
`timescale 1ns/1ps
module tb_sdirq_status_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [11:0] ev = '0;
  logic        card_det = 1'b0, dat0 = 1'b0, cmd_busy = 1'b0;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sdirq_status_regs dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .resp_done_i(ev[0]), .data_done_i(ev[1]), .err_cmd_idx_i(ev[2]),
    .err_crc_i(ev[3]), .err_end_bit_i(ev[4]), .err_timeout_i(ev[5]),
    .err_ill_wr_i(ev[6]), .err_ill_rd_i(ev[7]), .err_resp_to_i(ev[8]),
    .rd_buf_fill_i(ev[9]), .wr_buf_empty_i(ev[10]), .err_ill_acc_i(ev[11]),
    .card_det_i(card_det), .dat0_i(dat0), .cmd_busy_i(cmd_busy),
    .irq_o(irq)
  );

  localparam logic [11:0] A_S1 = 12'h038, A_S2 = 12'h03C,
                          A_M1 = 12'h040, A_M2 = 12'h044;

  // expected (word, bit) for each event index, from R3
  function automatic int ev_word(input int i);
    ev_word = (i < 2) ? 1 : 2;
  endfunction
  function automatic int ev_bit(input int i);
    case (i)
      0: ev_bit = 0;  1: ev_bit = 2;  2: ev_bit = 0;  3: ev_bit = 1;
      4: ev_bit = 2;  5: ev_bit = 3;  6: ev_bit = 4;  7: ev_bit = 5;
      8: ev_bit = 6;  9: ev_bit = 8;  10: ev_bit = 9; default: ev_bit = 15;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input int i);
    @(negedge clk);
    ev[i] = 1'b1;
    @(negedge clk);
    ev[i] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_S1, d); chk("R2 word1 reset", d, 32'h0);
    rd(A_S2, d); chk("R2 word2 reset", d, 32'h0);
    rd(A_M1, d); chk("R2 mask1 reset", d, 32'hFFFF_FFFF);
    rd(A_M2, d); chk("R2 mask2 reset", d, 32'hFFFF_FFFF);
    chk("R2 irq reset", {31'b0, irq}, 32'h0);
    rd(12'h048, d); chk("R1 unmapped address", d, 32'h0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    for (int i = 0; i < 12; i++) begin
      wr(A_S1, 32'h0);
      wr(A_S2, 32'h0);
      pulse(i);
      rd(ev_word(i) == 1 ? A_S1 : A_S2, d);
      chk($sformatf("R3 event %0d sets its bit", i), d, 32'h1 << ev_bit(i));
      rd(ev_word(i) == 1 ? A_S2 : A_S1, d);
      chk($sformatf("R3 event %0d other word", i), d, 32'h0);
    end
    chk("R9 masked flags quiet", {31'b0, irq}, 32'h0);
    wr(A_S2, 32'h0);
  endtask

  task automatic t_edge_hold();
    logic [31:0] d;
    @(negedge clk); ev[9] = 1'b1;
    rd(A_S2, d); chk("R4 buffer ready set", d, 32'h100);
    wr(A_S2, 32'h0);
    repeat (3) @(negedge clk);
    rd(A_S2, d); chk("R4 stays clear while held", d, 32'h0);
    @(negedge clk); ev[9] = 1'b0;
    @(negedge clk); ev[9] = 1'b1;
    rd(A_S2, d); chk("R4 re-fires on new edge", d, 32'h100);
    @(negedge clk); ev[9] = 1'b0;
    wr(A_S2, 32'h0);
  endtask

  task automatic t_write_keep();
    logic [31:0] d;
    pulse(3); pulse(5);
    rd(A_S2, d); chk("R5 two flags set", d, 32'h0A);
    wr(A_S2, 32'h0000_0002);
    rd(A_S2, d); chk("R5 one keeps zero clears", d, 32'h02);
    wr(A_S2, 32'h0);
    rd(A_S2, d); chk("R5 zero write clears", d, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    pulse(2);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_S2; reg_wdata = 32'h0; ev[3] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; ev[3] = 1'b0;
    rd(A_S2, d); chk("R6 set beats clear", d, 32'h02);
    wr(A_S2, 32'h0);
  endtask

  task automatic t_live_card();
    logic [31:0] d;
    card_det = 1'b1;
    repeat (4) @(negedge clk);
    rd(A_S1, d); chk("R8 insert and R7 card level", d, 32'h30);
    wr(A_S1, 32'h0);
    rd(A_S1, d); chk("R7 card level ignores write", d, 32'h20);
    dat0 = 1'b1; cmd_busy = 1'b1;
    repeat (3) @(negedge clk);
    rd(A_S2, d); chk("R7 DAT0 and busy live", d, 32'h4080);
    wr(A_S2, 32'h0);
    rd(A_S2, d); chk("R7 live bits ignore write", d, 32'h4080);
    wr(A_M1, 32'h0); wr(A_M2, 32'h0);
    #1; chk("R9 live levels raise no irq", {31'b0, irq}, 32'h0);
    card_det = 1'b0;
    repeat (4) @(negedge clk);
    rd(A_S1, d); chk("R8 removal flag", d, 32'h08);
    chk("R9 unmasked flag raises irq", {31'b0, irq}, 32'h1);
    wr(A_S1, 32'h0);
    #1; chk("R9 irq drops after clear", {31'b0, irq}, 32'h0);
    dat0 = 1'b0; cmd_busy = 1'b0;
    wr(A_M1, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq_mask();
    logic [31:0] d;
    wr(A_M2, ~32'h2);
    pulse(5);
    #1; chk("R9 masked timeout no irq", {31'b0, irq}, 32'h0);
    pulse(3);
    #1; chk("R9 unmasked CRC irq", {31'b0, irq}, 32'h1);
    wr(A_S2, 32'h0);
    #1; chk("R9 clear drops irq", {31'b0, irq}, 32'h0);
    wr(A_M1, 32'h1234_5678);
    rd(A_M1, d); chk("R10 mask1 readback", d, 32'h1234_5678);
    wr(A_M2, 32'hA5C3_0F96);
    rd(A_M2, d); chk("R10 mask2 readback", d, 32'hA5C3_0F96);
    rd(A_S1, d); chk("R1 word1 address", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_events();
    t_edge_hold();
    t_write_keep();
    t_set_wins();
    t_live_card();
    t_irq_mask();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule